// File: doc/BRIEF.md
# Indexed Palette Access Port

This block gives a CPU byte-wide, indirect access to a colour palette store of 64 little-endian 16-bit words (128 bytes). There are two channels. The background channel covers words 0 to 31. The object channel covers words 32 to 63.

Each channel has two registers:
- A pointer register holds a 6-bit byte index and an auto-advance flag.
- A data register reads or writes the palette byte that the index selects. An even index selects the low byte of word `index>>1`. An odd index selects the high byte.

After a data write, the channel can step its index by one. A run of writes can therefore load a whole palette without rewriting the pointer.

The CPU drives a 2-bit register select, write data, and single-cycle write and read strobes. A read returns its byte on `rd_data` in the cycle after the strobe. The byte stays there until the next read.

Top module: `pal_port`

## Requirements
- R1: After reset, every palette byte is 0x00, and both channels hold index 0 with auto-advance off. A pointer read therefore returns 0x40.
- R2: The register select is decoded as follows: bit 0 chooses pointer (0) or data (1), and bit 1 chooses background (0) or object (1). A pointer write stores write-data bits [5:0] as the index and bit 7 as the auto-advance flag. A pointer read returns {flag, 1, index}, so bit 6 always reads as 1.
- R3: A data read returns the byte at the channel's current index. An even index gives the low byte of word index>>1, and an odd index gives the high byte.
- R4: Object channel index i addresses word 32 + (i>>1). Background channel index i addresses word i>>1. The two halves never alias.
- R5: A data write replaces only the selected byte. All other bytes keep their values, and a following data read returns the new byte.
- R6: A data write with auto-advance set moves that channel's index up by one, wrapping from 63 to 0. The flag stays set.
- R7: A data write with auto-advance clear leaves the index unchanged.
- R8: Reads of either register change no index, flag or palette byte.
- R9: `rd_data` is loaded only in the cycle after a read strobe and holds its value otherwise. When read and write strobes coincide, the read returns the state from before the write.
- R10: A write to one channel's pointer or data register leaves the other channel's index and flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 2 | Register select: bit 0 data/pointer, bit 1 object/background |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |

## Verification
The embedded properties check, on every cycle, the following:
- pointer reads return bit 6 set;
- an auto-advancing write steps the index by exactly one, with wrap, and keeps the flag;
- a non-advancing write or a cycle without any write leaves the index and flag unchanged;
- `rd_data` stays stable when no read is strobed.

Only the bench scenarios can show the following:
- the byte-to-word mapping, including high/low byte order and the object offset of 32 words;
- that a data write touches a single byte;
- the reset contents;
- the read-before-write order when both strobes coincide.

The bench shows these by comparing each read against a byte-level model of the palette.

// File: rtl/pal_port.sv
module pal_port #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data
);
  localparam int CH    = 2;
  localparam int BYTES = CH << IDX_W;
  localparam int AW    = IDX_W + 1;

  logic [IDX_W-1:0]  idx [CH];
  logic              adv [CH];
  logic [DATA_W-1:0] mem [BYTES];

  wire              is_data = sel[0];
  wire              ch      = sel[1];
  wire [IDX_W-1:0]  cur_idx = idx[ch];
  wire              cur_adv = adv[ch];
  wire [AW-1:0]     ptr     = {ch, cur_idx};

  logic [DATA_W-1:0] ptr_view;
  always_comb begin
    ptr_view = '0;
    ptr_view[IDX_W-1:0] = cur_idx;
    ptr_view[DATA_W-2]  = 1'b1;
    ptr_view[DATA_W-1]  = cur_adv;
  end

  for (genvar c = 0; c < CH; c++) begin : g_ch
    wire hit = wr_en && (ch == c[0]);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        idx[c] <= '0;
        adv[c] <= 1'b0;
      end else if (hit && !is_data) begin
        idx[c] <= wr_data[IDX_W-1:0];
        adv[c] <= wr_data[DATA_W-1];
      end else if (hit && is_data && adv[c]) begin
        idx[c] <= idx[c] + IDX_W'(1);
      end
    end

    assert_step_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && is_data && adv[c]) |=> (adv[c] && idx[c] == $past(idx[c]) + IDX_W'(1)));
    assert_hold_idx_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && is_data && !adv[c]) |=> $stable(idx[c]));
    assert_no_write_no_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr_en && ch == c[0])) |=> ($stable(idx[c]) && $stable(adv[c])));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BYTES; i++) mem[i] <= '0;
    end else if (wr_en && is_data) begin
      mem[ptr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= is_data ? mem[ptr] : ptr_view;
  end

  assert_ptr_bit6_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !is_data) |=> rd_data[DATA_W-2]);
  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en) |=> $stable(rd_data));
endmodule

// File: tb/pal_port_bench.sv
module pal_port_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = '0;
  logic [7:0] wr_data = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  logic [7:0] m_mem [128];
  logic [5:0] m_idx [2];
  logic       m_adv [2];

  pal_port u_pal_port (.clk(clk), .rst_n(rst_n), .sel(sel), .wr_data(wr_data),
                       .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] exp_read(input logic [1:0] s);
    if (s[0]) return m_mem[{s[1], m_idx[s[1]]}];
    return {m_adv[s[1]], 1'b1, m_idx[s[1]]};
  endfunction

  function automatic void model_write(input logic [1:0] s, input logic [7:0] d);
    if (!s[0]) begin
      m_idx[s[1]] = d[5:0];
      m_adv[s[1]] = d[7];
    end else begin
      m_mem[{s[1], m_idx[s[1]]}] = d;
      if (m_adv[s[1]]) m_idx[s[1]] = m_idx[s[1]] + 6'd1;
    end
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    sel = s; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(s, d);
  endtask

  task automatic do_read(input logic [1:0] s, input string tag);
    logic [7:0] e;
    @(negedge clk);
    sel = s; rd_en = 1'b1;
    e = exp_read(s);
    @(negedge clk);
    rd_en = 1'b0;
    check(tag, rd_data, e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'd2024));
    for (int i = 0; i < 128; i++) m_mem[i] = '0;
    for (int c = 0; c < 2; c++) begin m_idx[c] = '0; m_adv[c] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    do_read(2'b00, "R1 bg pointer");
    do_read(2'b10, "R1 obj pointer");
    do_read(2'b01, "R1 bg data");
    do_read(2'b11, "R1 obj data");

    // R2 pointer fields, R6 wrap at 63
    do_write(2'b00, 8'hBF);
    do_read(2'b00, "R2 pointer readback");
    do_write(2'b01, 8'h12);
    do_read(2'b00, "R6 wrap to 0 keeps flag");
    // R7 no advance
    do_write(2'b00, 8'h05);
    do_write(2'b01, 8'h34);
    do_read(2'b00, "R7 index held");
    do_read(2'b01, "R5 byte written");
    // R3 low/high byte order
    do_write(2'b00, 8'h84);
    do_write(2'b01, 8'hA1);
    do_write(2'b01, 8'hB2);
    do_write(2'b00, 8'h04);
    do_read(2'b01, "R3 even index low byte");
    do_write(2'b00, 8'h05);
    do_read(2'b01, "R3 odd index high byte");
    // R4 object half separate, R10 independence
    do_write(2'b10, 8'h84);
    do_write(2'b11, 8'hC7);
    do_read(2'b00, "R10 bg pointer unchanged");
    do_read(2'b11, "R4 obj index 5 after step");
    do_write(2'b10, 8'h04);
    do_read(2'b11, "R4 obj byte distinct");
    do_write(2'b00, 8'h04);
    do_read(2'b01, "R4 bg byte not aliased");
    // R8 reads leave state alone
    do_read(2'b01, "R8 repeated read");
    do_read(2'b00, "R8 pointer after reads");
    // R9 hold and read-before-write
    held = rd_data;
    do_write(2'b01, 8'h5A);
    do_write(2'b11, 8'h6B);
    check("R9 rd_data held", rd_data, held);
    @(negedge clk);
    sel = 2'b01; rd_en = 1'b1; wr_en = 1'b1; wr_data = 8'hE3;
    held = exp_read(2'b01);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    model_write(2'b01, 8'hE3);
    check("R9 read before write", rd_data, held);
    do_read(2'b01, "R5 coincident write landed");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] s;
      int op;
      s  = 2'($urandom);
      op = $urandom % 3;
      if (op == 0) do_read(s, s[0] ? "R3 random data read" : "R2 random pointer read");
      else do_write(s, 8'($urandom));
    end
    for (int c = 0; c < 2; c++) begin
      do_read({c[0], 1'b0}, "R6 final pointer");
      do_read({c[0], 1'b1}, "R5 final data");
    end
    finish_run();
  end
endmodule